// File: doc/BRIEF.md
# Indexed Address Sequencer

This block runs the bus cycles of an absolute indexed operand access for an 8-bit processor with a 16-bit address space. When started, it fetches a two-byte base address from the instruction stream, low byte first. While the high byte is on the bus, it adds an unsigned 8-bit index to the low byte. It then issues the data cycle at the effective address. A read that stays within the 256-byte page of the base goes straight to the data. A read that crosses a page pays one extra cycle: a dummy read at the uncorrected address, while the high byte is incremented.

Writes and read-modify-write operations always take that dummy read, so that no store can ever land on an uncorrected address. A read-modify-write then reads the operand. It writes the unmodified value back, and finally writes the modified value supplied by the surrounding core. Every bus cycle carries a type tag. A one-cycle done flag marks the last cycle so that the next opcode fetch can follow immediately. Opcode decode, the ALU and the register file sit outside this block.

Top module: `index_seq`

## Requirements
- R1: While reset is held low and in every idle cycle, `addr` is 0, `rnw` is 1, `cyc_type` is 0 (idle), `done` is 0 and `wr_data` is 0.
- R2: After `start` is sampled high in an idle cycle, the next two bus cycles are fetches (`cyc_type` 1) at `opnd_addr` and then at `opnd_addr + 1` modulo 65536. The first fetch returns the low base byte and the second returns the high base byte.
- R3: For `op_class` 0 (read), or 3 (treated as read), with no carry out of low byte plus index, the cycle after the second fetch is a real read (`cyc_type` 3) at base + index, with `done` high. The operation takes three bus cycles.
- R4: For a read whose low byte plus index carries, the cycle after the second fetch is a dummy read (`cyc_type` 2). Its address is {base high byte, low sum}. A real read at the corrected address with `done` high follows.
- R5: For `op_class` 1 (write), the second fetch is always followed by a dummy read at {base high byte, low sum}. This is then followed by one write (`cyc_type` 4, `rnw` 0) of `wr_data_in` at the effective address with `done` high. No write is ever issued at any other address.
- R6: For `op_class` 2 (read-modify-write), the cycles are fetch, fetch, dummy read, real read, write of the value read, and write of `wr_data_in`. All data cycles after the dummy use the effective address, and `done` is high only in the last write.
- R7: The effective address is (base + index) modulo 65536. A carry out of the high byte is dropped.
- R8: `done` is high for exactly one cycle, the final bus cycle, and the block is idle in the following cycle. `start` and the `op_class`, `index` and `opnd_addr` inputs are ignored while an operation is running.
- R9: `rnw` is 0 only in cycles tagged write, and `wr_data` is 0 in every cycle that is not a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op_class | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 read |
| index | input | 8 | Unsigned index added to the base |
| opnd_addr | input | 16 | Address of the low base byte in the instruction stream |
| rd_data | input | 8 | Data returned by memory in the current bus cycle |
| wr_data_in | input | 8 | Store value, or modified value for read-modify-write |
| addr | output | 16 | Bus address |
| rnw | output | 1 | 1 read cycle, 0 write cycle |
| cyc_type | output | 3 | 0 idle, 1 fetch, 2 dummy read, 3 real read, 4 write |
| wr_data | output | 8 | Data driven in write cycles |
| done | output | 1 | High in the last bus cycle of an operation |

## Verification
The assertions assume that memory answers in the same cycle, so `rd_data` is valid for the address presented in that cycle. They also assume that `wr_data_in` is stable while a write cycle is on the bus. The bench models memory with a lookup that it refreshes from `addr` on the falling edge, and it holds `wr_data_in` for the whole operation. The bench raises `start` only from idle, except in one deliberate test that holds it high and changes the operation inputs in mid-flight to show that they are ignored.

// File: rtl/index_seq_pkg.sv
// Shared types for the indexed address sequencer.
// Assumes: cycle-type and operation encodings are visible at the block ports.
package index_seq_pkg;

    typedef enum logic [2:0] {
        CT_IDLE  = 3'd0,
        CT_FETCH = 3'd1,
        CT_DUMMY = 3'd2,
        CT_READ  = 3'd3,
        CT_WRITE = 3'd4
    } cyc_t;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_RMW   = 2'd2,
        OP_READ2 = 2'd3
    } op_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FLO   = 3'd1,
        ST_FHI   = 3'd2,
        ST_DUMMY = 3'd3,
        ST_READ  = 3'd4,
        ST_WBACK = 3'd5,
        ST_WMOD  = 3'd6,
        ST_WRITE = 3'd7
    } st_t;

endpackage

// File: rtl/index_seq_adder.sv
// Low-byte adder for the effective address.
// Adds the fetched low base byte and the index, giving the low sum and the
// carry into the high byte. Built bit by bit as a ripple chain so that the
// carry is available in the same cycle as the high-byte fetch.
// Assumes: both operands are unsigned and DATA_W bits wide.
module index_seq_adder #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              carry_o
);

    logic [DATA_W:0] chain;

    assign chain[0] = 1'b0;

    // One full adder per bit of the low byte.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign sum_o[i]    = a_i[i] ^ b_i[i] ^ chain[i];
        assign chain[i+1]  = (a_i[i] & b_i[i]) | (chain[i] & (a_i[i] ^ b_i[i]));
    end

    assign carry_o = chain[DATA_W];

endmodule

// File: rtl/index_seq_ctrl.sv
// Cycle controller of the indexed address sequencer.
// Walks the bus-cycle sequence for one operation and decodes each state into
// the cycle tag, the read/write strobe and the done flag.
// Assumes: carry_i is valid while in ST_FHI (the low byte was captured in ST_FLO).
module index_seq_ctrl
    import index_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] op_class,
    input  logic       carry_i,
    output st_t        state_o,
    output cyc_t       cyc_o,
    output logic       rnw_o,
    output logic       done_o
);

    st_t state_q, state_d;
    op_t op_q;
    logic is_read;

    assign is_read = (op_q == OP_READ) || (op_q == OP_READ2);

    // Next-state selection for the bus-cycle sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = start ? ST_FLO : ST_IDLE;
            ST_FLO:   state_d = ST_FHI;
            ST_FHI:   state_d = (is_read && !carry_i) ? ST_READ : ST_DUMMY;
            ST_DUMMY: state_d = (op_q == OP_WRITE) ? ST_WRITE : ST_READ;
            ST_READ:  state_d = (op_q == OP_RMW) ? ST_WBACK : ST_IDLE;
            ST_WBACK: state_d = ST_WMOD;
            ST_WMOD:  state_d = ST_IDLE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latch the operation class when an idle start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)                             op_q <= OP_READ;
        else if (state_q == ST_IDLE && start)   op_q <= op_t'(op_class);
    end

    // Decode the state into bus-cycle tag, strobe and done.
    always_comb begin
        cyc_o  = CT_IDLE;
        rnw_o  = 1'b1;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  cyc_o = CT_IDLE;
            ST_FLO:   cyc_o = CT_FETCH;
            ST_FHI:   cyc_o = CT_FETCH;
            ST_DUMMY: cyc_o = CT_DUMMY;
            ST_READ: begin
                cyc_o  = CT_READ;
                done_o = (op_q != OP_RMW);
            end
            ST_WBACK: begin
                cyc_o = CT_WRITE;
                rnw_o = 1'b0;
            end
            ST_WMOD, ST_WRITE: begin
                cyc_o  = CT_WRITE;
                rnw_o  = 1'b0;
                done_o = 1'b1;
            end
            default: cyc_o = CT_IDLE;
        endcase
    end

    assign state_o = state_q;

    AST_READ_NO_PENALTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FHI && is_read && !carry_i) |=> (state_q == ST_READ)); // R3
    AST_READ_CROSS_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FHI && is_read && carry_i) |=> (state_q == ST_DUMMY)); // R4
    AST_STORE_ALWAYS_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FHI && !is_read) |=> (state_q == ST_DUMMY)); // R5
    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (state_q == ST_IDLE)); // R8
    AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(op_q)); // R8

endmodule

// File: rtl/index_seq_datapath.sv
// Address datapath of the indexed address sequencer.
// Holds the operand pointer, index, base bytes, low sum, carry and the read
// value, and drives the bus address and write data for each state.
// Assumes: rd_data is valid in the cycle its address is presented.
module index_seq_datapath
    import index_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  st_t               state_i,
    input  logic              start,
    input  logic [ADDR_W-1:0] opnd_addr,
    input  logic [DATA_W-1:0] index,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] wr_data_in,
    output logic              carry_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wr_data_o
);

    logic [ADDR_W-1:0] ptr_q;
    logic [DATA_W-1:0] idx_q;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hi_q;
    logic [DATA_W-1:0] sum_q;
    logic              carry_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] sum_w;
    logic              carry_w;

    index_seq_adder #(.DATA_W(DATA_W)) u_add (
        .a_i     (lo_q),
        .b_i     (idx_q),
        .sum_o   (sum_w),
        .carry_o (carry_w)
    );

    assign carry_o = carry_w;

    // Capture the operand pointer and the index when an operation starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            idx_q <= '0;
        end else if (state_i == ST_IDLE && start) begin
            ptr_q <= opnd_addr;
            idx_q <= index;
        end
    end

    // Capture the base bytes, the low sum and its carry; fix the high byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q    <= '0;
            hi_q    <= '0;
            sum_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            if (state_i == ST_FLO) lo_q <= rd_data;
            if (state_i == ST_FHI) begin
                hi_q    <= rd_data;
                sum_q   <= sum_w;
                carry_q <= carry_w;
            end
            if (state_i == ST_DUMMY && carry_q) hi_q <= hi_q + 1'b1;
        end
    end

    // Keep the value read in the real read for the read-modify-write write-back.
    always_ff @(posedge clk) begin
        if (!rst_n)                    data_q <= '0;
        else if (state_i == ST_READ)   data_q <= rd_data;
    end

    // Bus address for each state.
    always_comb begin
        unique case (state_i)
            ST_IDLE: addr_o = '0;
            ST_FLO:  addr_o = ptr_q;
            ST_FHI:  addr_o = ptr_q + 1'b1;
            default: addr_o = {hi_q, sum_q};
        endcase
    end

    // Write data for each state.
    always_comb begin
        unique case (state_i)
            ST_WBACK:          wr_data_o = data_q;
            ST_WMOD, ST_WRITE: wr_data_o = wr_data_in;
            default:           wr_data_o = '0;
        endcase
    end

    AST_HI_FETCH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_FHI) |-> (addr_o == $past(addr_o) + 1'b1)); // R2
    AST_FIX_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_DUMMY) |=> (addr_o[DATA_W-1:0] == $past(addr_o[DATA_W-1:0]))); // R4
    AST_WBACK_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_WBACK) |-> (wr_data_o == $past(rd_data))); // R6

endmodule

// File: rtl/index_seq.sv
// Top of the indexed address sequencer.
// Joins the cycle controller and the address datapath and presents the bus.
// Assumes: memory answers in the same cycle; wr_data_in is stable in writes.
module index_seq
    import index_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_class,
    input  logic [DATA_W-1:0] index,
    input  logic [ADDR_W-1:0] opnd_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] wr_data_in,
    output logic [ADDR_W-1:0] addr,
    output logic              rnw,
    output logic [2:0]        cyc_type,
    output logic [DATA_W-1:0] wr_data,
    output logic              done
);

    st_t  state;
    cyc_t cyc;
    logic carry;

    index_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_class (op_class),
        .carry_i  (carry),
        .state_o  (state),
        .cyc_o    (cyc),
        .rnw_o    (rnw),
        .done_o   (done)
    );

    index_seq_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_i    (state),
        .start      (start),
        .opnd_addr  (opnd_addr),
        .index      (index),
        .rd_data    (rd_data),
        .wr_data_in (wr_data_in),
        .carry_o    (carry),
        .addr_o     (addr),
        .wr_data_o  (wr_data)
    );

    assign cyc_type = cyc;

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CT_WRITE) |-> ($past(cyc) == CT_DUMMY || $past(cyc) == CT_READ
                               || $past(cyc) == CT_WRITE)); // R5
    AST_WRITES_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CT_WRITE && $past(cyc) == CT_WRITE) |-> $stable(addr)); // R6
    AST_STROBE_MATCHES_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!rnw) |-> (cyc_type == 3'd4)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CT_IDLE) |-> (addr == '0 && rnw && !done)); // R1

endmodule

// File: tb/index_seq_bench.sv
module index_seq_bench;

    typedef struct {
        logic [15:0] addr;
        logic        rnw;
        logic [2:0]  cyc;
        logic        done;
        logic [7:0]  wd;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_class = 2'd0;
    logic [7:0]  index = 8'd0;
    logic [15:0] opnd_addr = 16'd0;
    logic [7:0]  rd_data = 8'd0;
    logic [7:0]  wr_data_in = 8'd0;
    logic [15:0] addr;
    logic        rnw;
    logic [2:0]  cyc_type;
    logic [7:0]  wr_data;
    logic        done;

    int checks = 0;
    int errors = 0;
    item_t exp_q[$];
    logic [7:0] mem [logic [15:0]];

    always #10 clk = ~clk;

    index_seq u_index_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op_class(op_class),
        .index(index), .opnd_addr(opnd_addr), .rd_data(rd_data),
        .wr_data_in(wr_data_in), .addr(addr), .rnw(rnw), .cyc_type(cyc_type),
        .wr_data(wr_data), .done(done)
    );

    function automatic logic [7:0] memrd(input logic [15:0] a);
        if (mem.exists(a)) return mem[a];
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    // Memory model: answers for the address presented in this cycle.
    always @(negedge clk) rd_data <= memrd(addr);

    function automatic item_t mk(input logic [15:0] a, input logic [2:0] c,
                                 input logic d, input logic [7:0] w, input string r);
        item_t it;
        it.addr = a; it.cyc = c; it.rnw = (c != 3'd4); it.done = d;
        it.wd = (c == 3'd4) ? w : 8'd0; it.req = r;
        return it;
    endfunction

    // Driver: computes the expected bus cycles, queues them and starts the op.
    task automatic run_op(input logic [1:0] op, input logic [15:0] pc,
                          input logic [15:0] base, input logic [7:0] idx,
                          input logic [7:0] wd, input bit poke, input string r);
        logic [8:0]  lsum;
        logic [15:0] eff, unc, pc1;
        lsum = {1'b0, base[7:0]} + {1'b0, idx};
        eff  = base + {8'd0, idx};
        unc  = {base[15:8], lsum[7:0]};
        pc1  = pc + 16'd1;
        mem[pc]  = base[7:0];
        mem[pc1] = base[15:8];
        exp_q.push_back(mk(pc,  3'd1, 1'b0, 8'd0, {r, "/R2"}));
        exp_q.push_back(mk(pc1, 3'd1, 1'b0, 8'd0, {r, "/R2"}));
        if ((op == 2'd0 || op == 2'd3) && !lsum[8]) begin
            exp_q.push_back(mk(eff, 3'd3, 1'b1, 8'd0, r));
        end else begin
            exp_q.push_back(mk(unc, 3'd2, 1'b0, 8'd0, r));
            if (op == 2'd1) begin
                exp_q.push_back(mk(eff, 3'd4, 1'b1, wd, {r, "/R9"}));
            end else if (op == 2'd2) begin
                exp_q.push_back(mk(eff, 3'd3, 1'b0, 8'd0, r));
                exp_q.push_back(mk(eff, 3'd4, 1'b0, memrd(eff), {r, "/R9"}));
                exp_q.push_back(mk(eff, 3'd4, 1'b1, wd, {r, "/R9"}));
            end else begin
                exp_q.push_back(mk(eff, 3'd3, 1'b1, 8'd0, r));
            end
        end
        @(negedge clk);
        op_class = op; opnd_addr = pc; index = idx; wr_data_in = wd;
        start = 1'b1;
        @(negedge clk);
        if (poke) begin
            // R8: hold start and change the operation inputs mid-flight.
            op_class = ~op; opnd_addr = ~pc; index = ~idx;
            @(negedge clk);
            @(negedge clk);
        end
        start = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compares every bus cycle with the next expected item.
    always @(negedge clk) begin
        if (rst_n && cyc_type != 3'd0) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8 unexpected cycle addr=%h cyc=%0d expected none", addr, cyc_type);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                if (addr !== e.addr || rnw !== e.rnw || cyc_type !== e.cyc ||
                    done !== e.done || wr_data !== e.wd) begin
                    errors++;
                    $display("FAIL %s got addr=%h rnw=%b cyc=%0d done=%b wd=%h exp addr=%h rnw=%b cyc=%0d done=%b wd=%h",
                             e.req, addr, rnw, cyc_type, done, wr_data,
                             e.addr, e.rnw, e.cyc, e.done, e.wd);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] s;
        repeat (3) @(negedge clk);
        // R1: reset state.
        checks++;
        if (addr !== 16'd0 || rnw !== 1'b1 || cyc_type !== 3'd0 || done !== 1'b0 || wr_data !== 8'd0) begin
            errors++;
            $display("FAIL R1 got addr=%h rnw=%b cyc=%0d done=%b exp 0000 1 0 0", addr, rnw, cyc_type, done);
        end
        rst_n = 1'b1;
        @(negedge clk);
        run_op(2'd0, 16'h0200, 16'h1234, 8'h10, 8'h00, 1'b0, "R3");
        run_op(2'd0, 16'h0210, 16'h12F0, 8'h20, 8'h00, 1'b0, "R4");
        run_op(2'd0, 16'h0220, 16'h40FF, 8'h00, 8'h00, 1'b0, "R3");
        run_op(2'd0, 16'h0230, 16'h40FF, 8'h01, 8'h00, 1'b0, "R4");
        run_op(2'd3, 16'h0240, 16'h5510, 8'h22, 8'h00, 1'b0, "R3");
        run_op(2'd3, 16'h0250, 16'h55E0, 8'h40, 8'h00, 1'b0, "R4");
        run_op(2'd1, 16'h0260, 16'h3000, 8'h05, 8'h9C, 1'b0, "R5");
        run_op(2'd1, 16'h0270, 16'h30FF, 8'hFF, 8'h3E, 1'b0, "R5");
        run_op(2'd2, 16'h0280, 16'h6100, 8'h07, 8'h77, 1'b0, "R6");
        run_op(2'd2, 16'h0290, 16'h61C0, 8'h80, 8'h12, 1'b0, "R6");
        run_op(2'd0, 16'h02A0, 16'hFFF0, 8'h20, 8'h00, 1'b0, "R7");
        run_op(2'd2, 16'h02B0, 16'hFFFF, 8'hFF, 8'hAB, 1'b0, "R7");
        run_op(2'd1, 16'hFFFF, 16'h7080, 8'h11, 8'h5D, 1'b0, "R2");
        run_op(2'd0, 16'h02C0, 16'h2222, 8'h01, 8'h00, 1'b1, "R8");
        run_op(2'd1, 16'h02D0, 16'h23F8, 8'h10, 8'hC4, 1'b1, "R8");
        s = 16'hACE1;
        for (int i = 0; i < 24; i++) begin
            s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
            run_op(s[1:0], 16'h0300 + 16'(i * 4), {s[7:0], s[15:8]}, s[11:4], s[9:2], 1'b0, "R7");
        end
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8 pending=%0d expected 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule